// File: doc/BRIEF.md
# Chiplet Control Register File

This block is a bank of 64-bit configuration and status registers that sits behind a simple word-indexed register bus. Each access names one 64-bit register by its word index and is always a full 64-bit word. A one-cycle read strobe loads the selected value into a registered read-data output. A one-cycle write strobe updates the selected register at the same clock edge.

There are six control registers and two configuration registers. Each of them has three write addresses. The home index replaces the value. The home index plus 0x10 sets bits: it ORs the write data in. The home index plus 0x20 clears every bit that is one in the write data. The two alias addresses are write-only. Four further registers accept only plain reads and writes: a status word, an interrupt mask, a protection-mode word and a lock word.

A single-cycle error pulse marks three cases: a read of a write-only alias, a read of an index that maps to nothing, and a write to such an index. The bus bridge above the block and any use of the register bits are outside this block.

Top module: `chiplet_ctrl_regfile`

## Requirements
- R1: While reset is high at a clock edge, every register, rdata and err become zero, so every readable index reads 0 after reset.
- R2: A write to a home index of a control register (0x00 to 0x05) or a configuration register (0x08, 0x09) replaces that register with wdata, and no error is flagged.
- R3: A write to a home index plus 0x10 ORs wdata into that register, and no error is flagged.
- R4: A write to a home index plus 0x20 clears in that register every bit that is one in wdata, and no error is flagged.
- R5: Indices 0x100, 0x101, 0x3FE and 0x3FF hold four independent plain read/write registers.
- R6: A read of any set or clear alias index returns 64'hFFFF_FFFF_FFFF_FFFF with err high for one cycle, and leaves the register behind the alias unchanged.
- R7: A read of an index that is neither a home index nor an alias returns all ones with err high.
- R8: A write to an index that is neither a home index nor an alias changes no register, and err is high for one cycle.
- R9: rdata takes the read result at the clock edge of the read strobe and keeps it until the next read. err is high only in the cycle after a flagged strobe.
- R10: When a read and a write to the same index are strobed in the same cycle, the read returns the value held before the write, and the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| addr | input | ADDR_W (10) | 64-bit word index |
| wdata | input | DATA_W (64) | Write data |
| rdata | output | DATA_W (64) | Registered read data, held between reads |
| err | output | 1 | One-cycle pulse on a write-only read or an unmapped access |

## Verification
The bench sweeps the whole 1024-entry index space, both for reads and for writes, and compares every result with a model built from the address rules alone. A decoder that mistook an alias for a home index, or that missed a gap between the register groups, would return stored data where all ones are due, or would let a stray write corrupt a register.

Set and clear are each tried on every aliased register with patterns that differ per register. An alias that wrote plainly or inverted the mask would show up on the next readback.

The bench also covers three timing cases. A read and a write strobed together must return the old value, not the new one. rdata must hold through idle cycles. err must fall after one cycle, not stick high.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

   // number of registers that accept only plain reads and writes
   localparam int unsigned CCR_N_PLAIN = 4;

   typedef enum logic [0:0] {
      CCR_KIND_ALIASED = 1'b0,
      CCR_KIND_PLAIN   = 1'b1
   } ccr_kind_e;

   // home index of the i-th aliased register: control block first, then configuration block
   function automatic int unsigned ccr_home(input int unsigned i,
                                            input int unsigned n_ctrl,
                                            input int unsigned conf_base);
      return (i < n_ctrl) ? i : conf_base + (i - n_ctrl);
   endfunction

endpackage

// File: rtl/ccr_decode.sv
module ccr_decode #(
   parameter int unsigned ADDR_W    = 10,
   parameter int unsigned N_CTRL    = 6,
   parameter int unsigned N_CONF    = 2,
   parameter int unsigned CONF_BASE = 'h08,
   parameter int unsigned SET_OFS   = 'h10,
   parameter int unsigned CLR_OFS   = 'h20,
   parameter int unsigned STAT_IDX  = 'h100,
   parameter int unsigned MASK_IDX  = 'h101,
   parameter int unsigned PROT_IDX  = 'h3FE,
   parameter int unsigned LOCK_IDX  = 'h3FF,
   localparam int unsigned N_ALIAS  = N_CTRL + N_CONF,
   localparam int unsigned N_REG    = N_ALIAS + ccr_pkg::CCR_N_PLAIN
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [N_REG-1:0]  hit_load,
   output logic [N_REG-1:0]  hit_set,
   output logic [N_REG-1:0]  hit_clr
);
   localparam int unsigned PLAIN_IDX [ccr_pkg::CCR_N_PLAIN] =
      '{STAT_IDX, MASK_IDX, PROT_IDX, LOCK_IDX};

   for (genvar i = 0; i < N_ALIAS; i++) begin : g_alias
      localparam int unsigned HOME = ccr_pkg::ccr_home(i, N_CTRL, CONF_BASE);
      assign hit_load[i] = (addr == ADDR_W'(HOME));
      assign hit_set[i]  = (addr == ADDR_W'(HOME + SET_OFS));
      assign hit_clr[i]  = (addr == ADDR_W'(HOME + CLR_OFS));
   end

   for (genvar j = 0; j < ccr_pkg::CCR_N_PLAIN; j++) begin : g_plain
      assign hit_load[N_ALIAS+j] = (addr == ADDR_W'(PLAIN_IDX[j]));
      assign hit_set[N_ALIAS+j]  = 1'b0;
      assign hit_clr[N_ALIAS+j]  = 1'b0;
   end
endmodule

// File: rtl/ccr_reg.sv
module ccr_reg #(
   parameter int unsigned        DATA_W = 64,
   parameter ccr_pkg::ccr_kind_e KIND   = ccr_pkg::CCR_KIND_ALIASED
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ld,
   input  logic              set,
   input  logic              clr,
   input  logic [DATA_W-1:0] wd,
   output logic [DATA_W-1:0] q
);
   if (KIND == ccr_pkg::CCR_KIND_ALIASED) begin : g_aliased
      always_ff @(posedge clk) begin
         if (rst)      q <= '0;
         else if (ld)  q <= wd;
         else if (set) q <= q | wd;
         else if (clr) q <= q & ~wd;
      end
   end else begin : g_plain
      logic unused_strobes;
      assign unused_strobes = set ^ clr;
      always_ff @(posedge clk) begin
         if (rst)     q <= '0;
         else if (ld) q <= wd;
      end
   end
endmodule

// File: rtl/ccr_rdmux.sv
module ccr_rdmux #(
   parameter int unsigned DATA_W = 64,
   parameter int unsigned N_REG  = 12
) (
   input  logic [N_REG-1:0]             sel,
   input  logic [N_REG-1:0][DATA_W-1:0] q,
   output logic [DATA_W-1:0]            dout
);
   always_comb begin
      dout = '0;
      for (int i = 0; i < N_REG; i++) begin
         dout = dout | (q[i] & {DATA_W{sel[i]}});
      end
   end
endmodule

// File: rtl/chiplet_ctrl_regfile.sv
module chiplet_ctrl_regfile #(
   parameter int unsigned DATA_W    = 64,
   parameter int unsigned ADDR_W    = 10,
   parameter int unsigned N_CTRL    = 6,
   parameter int unsigned N_CONF    = 2,
   parameter int unsigned CONF_BASE = 'h08,
   parameter int unsigned SET_OFS   = 'h10,
   parameter int unsigned CLR_OFS   = 'h20,
   parameter int unsigned STAT_IDX  = 'h100,
   parameter int unsigned MASK_IDX  = 'h101,
   parameter int unsigned PROT_IDX  = 'h3FE,
   parameter int unsigned LOCK_IDX  = 'h3FF
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              err
);
   localparam int unsigned N_ALIAS  = N_CTRL + N_CONF;
   localparam int unsigned N_REG    = N_ALIAS + ccr_pkg::CCR_N_PLAIN;
   localparam int unsigned ALIAS_HI = CONF_BASE + N_CONF;

   // elaboration-time parameter checks
   if (DATA_W < 1) begin : g_bad_width
      $error("chiplet_ctrl_regfile: DATA_W must be at least 1");
   end
   if (N_CTRL > CONF_BASE) begin : g_bad_conf
      $error("chiplet_ctrl_regfile: control block overlaps configuration block");
   end
   if (ALIAS_HI > SET_OFS || SET_OFS + ALIAS_HI > CLR_OFS) begin : g_bad_alias
      $error("chiplet_ctrl_regfile: alias windows overlap");
   end
   if (CLR_OFS + ALIAS_HI > STAT_IDX) begin : g_bad_plain
      $error("chiplet_ctrl_regfile: plain registers overlap the alias windows");
   end
   if (LOCK_IDX >= (1 << ADDR_W) || PROT_IDX >= (1 << ADDR_W)) begin : g_bad_addr
      $error("chiplet_ctrl_regfile: ADDR_W too narrow for register indices");
   end

   logic [N_REG-1:0]             hit_load, hit_set, hit_clr;
   logic [N_REG-1:0][DATA_W-1:0] q;
   logic [DATA_W-1:0]            mux_out;
   logic                         readable, any_hit;

   ccr_decode #(
      .ADDR_W   (ADDR_W),
      .N_CTRL   (N_CTRL),
      .N_CONF   (N_CONF),
      .CONF_BASE(CONF_BASE),
      .SET_OFS  (SET_OFS),
      .CLR_OFS  (CLR_OFS),
      .STAT_IDX (STAT_IDX),
      .MASK_IDX (MASK_IDX),
      .PROT_IDX (PROT_IDX),
      .LOCK_IDX (LOCK_IDX)
   ) u_dec (
      .addr    (addr),
      .hit_load(hit_load),
      .hit_set (hit_set),
      .hit_clr (hit_clr)
   );

   for (genvar i = 0; i < N_REG; i++) begin : g_reg
      localparam ccr_pkg::ccr_kind_e KIND =
         (i < N_ALIAS) ? ccr_pkg::CCR_KIND_ALIASED : ccr_pkg::CCR_KIND_PLAIN;
      ccr_reg #(
         .DATA_W(DATA_W),
         .KIND  (KIND)
      ) u_reg (
         .clk(clk),
         .rst(rst),
         .ld (wr_en & hit_load[i]),
         .set(wr_en & hit_set[i]),
         .clr(wr_en & hit_clr[i]),
         .wd (wdata),
         .q  (q[i])
      );
   end

   ccr_rdmux #(
      .DATA_W(DATA_W),
      .N_REG (N_REG)
   ) u_mux (
      .sel (hit_load),
      .q   (q),
      .dout(mux_out)
   );

   assign readable = |hit_load;
   assign any_hit  = |(hit_load | hit_set | hit_clr);

   always_ff @(posedge clk) begin
      if (rst) begin
         rdata <= '0;
         err   <= 1'b0;
      end else begin
         if (rd_en) rdata <= readable ? mux_out : {DATA_W{1'b1}};
         err <= (rd_en & ~readable) | (wr_en & ~any_hit);
      end
   end
endmodule

// File: rtl/ccr_chk.sv
module ccr_chk #(
   parameter int unsigned DATA_W    = 64,
   parameter int unsigned ADDR_W    = 10,
   parameter int unsigned N_CTRL    = 6,
   parameter int unsigned N_CONF    = 2,
   parameter int unsigned CONF_BASE = 'h08,
   parameter int unsigned SET_OFS   = 'h10,
   parameter int unsigned CLR_OFS   = 'h20,
   parameter int unsigned STAT_IDX  = 'h100,
   parameter int unsigned MASK_IDX  = 'h101,
   parameter int unsigned PROT_IDX  = 'h3FE,
   parameter int unsigned LOCK_IDX  = 'h3FF
) (
   input logic              clk,
   input logic              rst,
   input logic              rd_en,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] rdata,
   input logic              err
);
   function automatic logic is_home(input int unsigned v);
      return (v < N_CTRL) || (v >= CONF_BASE && v < CONF_BASE + N_CONF);
   endfunction

   function automatic logic is_readable(input logic [ADDR_W-1:0] a);
      int unsigned v;
      v = int'(a);
      return is_home(v) || v == STAT_IDX || v == MASK_IDX || v == PROT_IDX || v == LOCK_IDX;
   endfunction

   function automatic logic is_alias(input logic [ADDR_W-1:0] a);
      int unsigned v;
      v = int'(a);
      return (v >= SET_OFS && is_home(v - SET_OFS)) || (v >= CLR_OFS && is_home(v - CLR_OFS));
   endfunction

   // R6
   alias_read_ones_chk: assert property (@(posedge clk) disable iff (rst)
      rd_en && is_alias(addr) |=> (rdata == {DATA_W{1'b1}}) && err);

   // R7
   unmapped_read_ones_chk: assert property (@(posedge clk) disable iff (rst)
      rd_en && !is_readable(addr) && !is_alias(addr) |=> (rdata == {DATA_W{1'b1}}) && err);

   // R8
   unmapped_write_flag_chk: assert property (@(posedge clk) disable iff (rst)
      wr_en && !is_readable(addr) && !is_alias(addr) |=> err);

   // R9
   rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !rd_en |=> $stable(rdata));

   // R9
   err_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
      !rd_en && !wr_en |=> !err);

   // R2
   clean_access_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_en || wr_en) && !(rd_en && !is_readable(addr))
      && !(wr_en && !is_readable(addr) && !is_alias(addr)) |=> !err);
endmodule

bind chiplet_ctrl_regfile ccr_chk #(
   .DATA_W   (DATA_W),
   .ADDR_W   (ADDR_W),
   .N_CTRL   (N_CTRL),
   .N_CONF   (N_CONF),
   .CONF_BASE(CONF_BASE),
   .SET_OFS  (SET_OFS),
   .CLR_OFS  (CLR_OFS),
   .STAT_IDX (STAT_IDX),
   .MASK_IDX (MASK_IDX),
   .PROT_IDX (PROT_IDX),
   .LOCK_IDX (LOCK_IDX)
) u_chk (
   .clk  (clk),
   .rst  (rst),
   .rd_en(rd_en),
   .wr_en(wr_en),
   .addr (addr),
   .rdata(rdata),
   .err  (err)
);

// File: tb/sim_chiplet_ctrl_regfile.sv
module sim_chiplet_ctrl_regfile;
   localparam int NIDX = 1024;
   localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        rd_en = 1'b0;
   logic        wr_en = 1'b0;
   logic [9:0]  addr = '0;
   logic [63:0] wdata = '0;
   logic [63:0] rdata;
   logic        err;

   int total = 0;
   int bad = 0;
   logic [63:0] model [NIDX];

   always #2 clk = ~clk;

   chiplet_ctrl_regfile u0 (
      .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .err(err)
   );

   function automatic bit home_idx(input int a);
      return (a >= 0 && a < 6) || a == 8 || a == 9;
   endfunction
   function automatic bit plain_idx(input int a);
      return a == 'h100 || a == 'h101 || a == 'h3FE || a == 'h3FF;
   endfunction
   function automatic bit rd_ok(input int a);
      return home_idx(a) || plain_idx(a);
   endfunction
   function automatic bit alias_idx(input int a);
      return home_idx(a - 'h10) || home_idx(a - 'h20);
   endfunction
   function automatic logic [63:0] pat(input int a, input logic [63:0] salt);
      return salt ^ (64'(a) * 64'h9E37_79B9_7F4A_7C15);
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_read(input int a, output logic [63:0] d, output logic e);
      @(negedge clk);
      rd_en = 1'b1; addr = 10'(a);
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata; e = err;
   endtask

   task automatic do_write(input int a, input logic [63:0] v, output logic e);
      @(negedge clk);
      wr_en = 1'b1; addr = 10'(a); wdata = v;
      @(negedge clk);
      wr_en = 1'b0;
      e = err;
   endtask

   task automatic readback_all(input string req);
      logic [63:0] d;
      logic e;
      for (int a = 0; a < NIDX; a++) begin
         if (rd_ok(a)) begin
            do_read(a, d, e);
            check(req, d, model[a]);
         end
      end
   endtask

   initial begin
      #(4 * 150000);
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [63:0] d, v, hold;
      logic e;
      for (int a = 0; a < NIDX; a++) model[a] = '0;

      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R1: reset state at the ports
      check("R1 rdata", rdata, 64'h0);
      check("R1 err", 64'(err), 64'h0);

      // full read sweep after reset: R1 / R6 / R7
      for (int a = 0; a < NIDX; a++) begin
         do_read(a, d, e);
         if (rd_ok(a)) begin
            check("R1 read", d, 64'h0);
            check("R1 err", 64'(e), 64'h0);
         end else if (alias_idx(a)) begin
            check("R6 data", d, ONES);
            check("R6 err", 64'(e), 64'h1);
         end else begin
            check("R7 data", d, ONES);
            check("R7 err", 64'(e), 64'h1);
         end
      end

      // R2 / R5: plain writes to every readable index
      for (int a = 0; a < NIDX; a++) begin
         if (rd_ok(a)) begin
            v = pat(a, 64'hA5C3_0F96_1E2D_4B87);
            do_write(a, v, e);
            model[a] = v;
            check(home_idx(a) ? "R2 err" : "R5 err", 64'(e), 64'h0);
         end
      end
      readback_all("R2/R5 readback");

      // R3: set alias
      for (int a = 0; a < 16; a++) begin
         if (home_idx(a)) begin
            v = pat(a, 64'h0F0F_3C3C_F00F_5A5A);
            do_write(a + 'h10, v, e);
            model[a] = model[a] | v;
            check("R3 err", 64'(e), 64'h0);
            do_read(a, d, e);
            check("R3 value", d, model[a]);
         end
      end

      // R4: clear alias
      for (int a = 0; a < 16; a++) begin
         if (home_idx(a)) begin
            v = pat(a, 64'h6996_C33C_0FF0_A55A);
            do_write(a + 'h20, v, e);
            model[a] = model[a] & ~v;
            check("R4 err", 64'(e), 64'h0);
            do_read(a, d, e);
            check("R4 value", d, model[a]);
         end
      end

      // R6: reading an alias returns ones and leaves the register alone
      for (int a = 0; a < 64; a++) begin
         if (alias_idx(a)) begin
            do_read(a, d, e);
            check("R6 data", d, ONES);
            check("R6 err", 64'(e), 64'h1);
            do_read(home_idx(a - 'h10) ? a - 'h10 : a - 'h20, d, e);
            check("R6 untouched", d, model[home_idx(a - 'h10) ? a - 'h10 : a - 'h20]);
         end
      end

      // R8: writes to every unmapped index
      for (int a = 0; a < NIDX; a++) begin
         if (!rd_ok(a) && !alias_idx(a)) begin
            do_write(a, ONES, e);
            check("R8 err", 64'(e), 64'h1);
         end
      end
      readback_all("R8 readback");

      // R9: hold between reads and one-cycle err
      do_read('h100, hold, e);
      repeat (3) @(negedge clk);
      check("R9 hold", rdata, hold);
      check("R9 err idle", 64'(err), 64'h0);
      do_read('h7, d, e);
      check("R9 err pulse", 64'(e), 64'h1);
      @(negedge clk);
      check("R9 err drop", 64'(err), 64'h0);
      check("R9 hold ones", rdata, ONES);

      // R10: read and write to the same index together
      @(negedge clk);
      rd_en = 1'b1; wr_en = 1'b1; addr = 10'h101; wdata = 64'h1357_9BDF_0246_8ACE;
      @(negedge clk);
      rd_en = 1'b0; wr_en = 1'b0;
      check("R10 old value", rdata, model['h101]);
      model['h101] = 64'h1357_9BDF_0246_8ACE;
      do_read('h101, d, e);
      check("R10 new value", d, model['h101]);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule